// File: doc/BRIEF.md
# Compare-Triggered Timer Channel

This block is one 16-bit up-counter channel driven from a small synchronous register port. A free-running divider on the system clock produces one-cycle count pulses at a rate picked by a clock-select field. While the channel's clock is running, each pulse advances the counter by one. A command register starts, stops and restarts the count. The clock-disable command overrides the clock-enable command.

A loadable limit value is compared with the counter on every count pulse. A match sets a sticky status flag. If the compare trigger is enabled in the mode register, the match also returns the counter to zero and keeps the clock running, so the channel gives a periodic event every limit+1 count pulses. Interrupt enable bits are set and cleared through two separate write-one registers. A single interrupt output is raised whenever an enabled status flag is set. Reading the status register acknowledges the flag.

Register word addresses are: 0 command (write-only), 1 mode, 2 limit, 3 counter (read-only), 4 status, 5 interrupt set-enable, 6 interrupt clear-enable, 7 interrupt mask (read-only).

Top module: `tmr_chan`

## Requirements
- R1: After reset the clock is stopped, the counter reads 0, status reads 0, the interrupt mask reads 0 and `irq` is low.
- R2: In the command word, bit 0 starts the counter clock and bit 1 stops it. When both bits are 1 in one write, the clock stays stopped. A write of 0 changes nothing. The command address always reads 0.
- R3: Command bit 2 clears the counter to zero and starts the clock. If bit 1 is also set in the same write, the counter is still cleared but the clock stays stopped.
- R4: Mode bits 2:0 select the count rate. The values 0, 1, 2, 3 and 4 give system clock /2, /8, /32, /128 and /1024. The values 5 to 7 also give /1024. A running window of 10×N system cycles advances the counter by exactly 10.
- R5: While the clock is stopped, the counter holds its value.
- R6: Status bit 4 is set on a count pulse where the running counter equals the limit. A read of the status register clears it. A new match in the same cycle as the read wins.
- R7: When mode bit 14 is 1, a match makes the counter 0 on the next pulse, so the counter cycles 0..limit. When mode bit 14 is 0, the match leaves the counter counting past the limit.
- R8: Status bit 16 reads 1 exactly while the counter clock is running.
- R9: A write with bit 4 set to the set-enable address sets the compare interrupt enable. A write with bit 4 set to the clear-enable address clears it. Other bits have no effect. The mask address returns the enable in bit 4.
- R10: `irq` is high exactly when status bit 4 and its enable are both 1.
- R11: The mode register reads back bits 2:0 and bit 14, with all other bits 0. The limit reads back its low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read acknowledges) |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Compare interrupt |

## Verification
The bench targets the enable-plus-disable command: a design that lets enable win would show status bit 16 set. It also targets trigger-plus-disable: a wrong design would either skip the clear or leave the clock running. Each rate select, including the aliased codes, is timed over an exact window. An off-by-one divider, or a count that slips on the stop write, would leave the counter at something other than 10. With the compare trigger on, the bench samples the counter every cycle and requires a maximum of exactly the limit. A design that wraps one too early or too late would fail. With the trigger off, the counter must run past the limit while the flag still sets and a cleared enable keeps `irq` low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIMIT = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd5;
    localparam logic [ADDR_W-1:0] A_IDIS  = 3'd6;
    localparam logic [ADDR_W-1:0] A_IMASK = 3'd7;

    localparam int CMD_ON_BIT   = 0;
    localparam int CMD_OFF_BIT  = 1;
    localparam int CMD_TRIG_BIT = 2;
    localparam int MODE_TRG_BIT = 14;
    localparam int ST_CMP_BIT   = 4;
    localparam int ST_RUN_BIT   = 16;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             trig_en;
        logic [CNT_W-1:0] limit;
        logic             flag;
        logic             mask;
    } regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } core_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAXK = DIV_W;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] low_mask;

    function automatic int sel_bits(input logic [SEL_W-1:0] s);
        int k;
        case (s)
            3'd0:    k = 1;
            3'd1:    k = 3;
            3'd2:    k = 5;
            3'd3:    k = 7;
            default: k = 10;
        endcase
        if (k > MAXK) k = MAXK;
        return k;
    endfunction

    always_comb begin
        div_d    = div_q + 1'b1;
        low_mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < sel_bits(sel)) low_mask[i] = 1'b1;
        end
        tick = &(div_q | ~low_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_on,
    input  logic             cmd_off,
    input  logic             cmd_trig,
    input  logic             trig_en,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             match
);
    core_t d, q;

    always_comb begin
        d     = q;
        match = q.run && tick && (q.cnt == limit);
        if (cmd_trig || cmd_off || cmd_on) begin
            if (cmd_trig) d.cnt = '0;
            if (cmd_off)  d.run = 1'b0;
            else          d.run = 1'b1;
        end else if (q.run && tick) begin
            if (match && trig_en) d.cnt = '0;
            else                  d.cnt = q.cnt + 1'b1;
        end
        count   = q.cnt;
        running = q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_trig |=> (count == '0)); // R3
    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> !running); // R2
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cmd_trig) |=> $stable(count)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (match && trig_en && !cmd_on && !cmd_off && !cmd_trig) |=> (count == '0 && running)); // R7
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    regs_t d, q;

    logic             wr_cmd, cmd_on, cmd_off, cmd_trig, tick, match, running;
    logic [CNT_W-1:0] count;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        wr_cmd   = wr_en && (addr == A_CMD);
        cmd_on   = wr_cmd && wdata[CMD_ON_BIT];
        cmd_off  = wr_cmd && wdata[CMD_OFF_BIT];
        cmd_trig = wr_cmd && wdata[CMD_TRIG_BIT];
    end

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (q.sel),
        .tick (tick)
    );

    tmr_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmd_on  (cmd_on),
        .cmd_off (cmd_off),
        .cmd_trig(cmd_trig),
        .trig_en (q.trig_en),
        .limit   (q.limit),
        .count   (count),
        .running (running),
        .match   (match)
    );

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                A_MODE: begin
                    d.sel     = wdata[SEL_W-1:0];
                    d.trig_en = wdata[MODE_TRG_BIT];
                end
                A_LIMIT: d.limit = wdata[CNT_W-1:0];
                A_IEN:   if (wdata[ST_CMP_BIT]) d.mask = 1'b1;
                A_IDIS:  if (wdata[ST_CMP_BIT]) d.mask = 1'b0;
                default: ;
            endcase
        end
        if (match)                             d.flag = 1'b1;
        else if (rd_en && (addr == A_STAT))    d.flag = 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE: begin
                rdata[SEL_W-1:0]    = q.sel;
                rdata[MODE_TRG_BIT] = q.trig_en;
            end
            A_LIMIT: rdata[CNT_W-1:0] = q.limit;
            A_COUNT: rdata[CNT_W-1:0] = count;
            A_STAT: begin
                rdata[ST_CMP_BIT] = q.flag;
                rdata[ST_RUN_BIT] = running;
            end
            A_IMASK: rdata[ST_CMP_BIT] = q.mask;
            default: ;
        endcase
        irq = q.flag && q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CMD) |-> (rdata == '0)); // R2
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> q.flag); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !q.mask |-> !irq); // R10
    AST_IEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IEN && wdata[ST_CMP_BIT]) |=> q.mask); // R9
    AST_RUN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT) |-> (rdata[ST_RUN_BIT] == running)); // R8
endmodule

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    tmr_chan u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // {is_read, address, write data or expected read data}
    localparam int NV = 20;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 3'd0, 32'h0000_0000},   // R2 command reads zero
        {1'b1, 3'd4, 32'h0000_0000},   // R1 status
        {1'b1, 3'd3, 32'h0000_0000},   // R1 counter
        {1'b1, 3'd7, 32'h0000_0000},   // R1 mask
        {1'b0, 3'd1, 32'hFFFF_FFFF},
        {1'b1, 3'd1, 32'h0000_4007},   // R11 mode readback
        {1'b0, 3'd2, 32'h1234_ABCD},
        {1'b1, 3'd2, 32'h0000_ABCD},   // R11 limit readback
        {1'b0, 3'd5, 32'hFFFF_FFFF},
        {1'b1, 3'd7, 32'h0000_0010},   // R9 set enable
        {1'b0, 3'd6, 32'hFFFF_FFEF},
        {1'b1, 3'd7, 32'h0000_0010},   // R9 other bits ignored
        {1'b0, 3'd6, 32'hFFFF_FFFF},
        {1'b1, 3'd7, 32'h0000_0000},   // R9 clear enable
        {1'b0, 3'd0, 32'h0000_0000},
        {1'b1, 3'd4, 32'h0000_0000},   // R2 zero command no effect
        {1'b0, 3'd0, 32'h0000_0003},
        {1'b1, 3'd4, 32'h0000_0000},   // R2 disable wins over enable
        {1'b0, 3'd1, 32'h0000_0000},
        {1'b1, 3'd1, 32'h0000_0000}    // R11 mode cleared
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic measure(input logic [2:0] sel, input int div);
        logic [31:0] v;
        wr(3'd1, {29'd0, sel});
        wr(3'd0, 32'h4);
        repeat (10 * div) @(negedge clk);
        wr(3'd0, 32'h2);
        rd(3'd3, v);
        check($sformatf("R4 sel=%0d", sel), v, 32'd10);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        logic [31:0] v, a, b;
        int mx;
        bit over;
        bit wrapped;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][35]) begin
                rd(VEC[i][34:32], v);
                check($sformatf("vector %0d", i), v, VEC[i][31:0]);
            end else begin
                wr(VEC[i][34:32], VEC[i][31:0]);
            end
        end

        // R2 / R8: enable runs the clock, count moves
        wr(3'd0, 32'h1);
        rd(3'd4, v);
        check("R8 running", v, 32'h0001_0000);
        repeat (20) @(negedge clk);
        rd(3'd3, v);
        check("R2 counts after enable", {31'd0, v != 0}, 32'd1);
        // R5: stopped counter holds
        wr(3'd0, 32'h2);
        rd(3'd3, a);
        repeat (30) @(negedge clk);
        rd(3'd3, b);
        check("R5 hold", b, a);
        rd(3'd4, v);
        check("R8 stopped", v, 32'h0);
        // R3: trigger with disable clears but stays stopped
        wr(3'd0, 32'h6);
        rd(3'd3, v);
        check("R3 cleared", v, 32'h0);
        rd(3'd4, v);
        check("R3 clock stays off", v, 32'h0);

        // R4: every rate select, including aliased codes
        wr(3'd2, 32'hFFFF);
        measure(3'd0, 2);
        measure(3'd1, 8);
        measure(3'd2, 32);
        measure(3'd3, 128);
        measure(3'd4, 1024);
        measure(3'd7, 1024);

        // R7 / R6 / R10: compare trigger cycles 0..limit
        wr(3'd2, 32'd5);
        wr(3'd1, 32'h4000);
        wr(3'd5, 32'h10);
        wr(3'd0, 32'h4);
        mx = 0; over = 0; wrapped = 0;
        for (int i = 0; i < 60; i++) begin
            rd(3'd3, v);
            if (int'(v) > mx) mx = int'(v);
            if (v > 5) over = 1;
            if (v == 0 && mx == 5) wrapped = 1;
        end
        check("R7 max equals limit", mx, 32'd5);
        check("R7 never past limit", {31'd0, over}, 32'd0);
        check("R7 wraps to zero", {31'd0, wrapped}, 32'd1);
        wr(3'd0, 32'h2);
        check("R10 irq raised", {31'd0, irq}, 32'd1);
        rd(3'd4, v);
        check("R6 flag set", v, 32'h10);
        check("R10 irq drops after ack", {31'd0, irq}, 32'd0);
        rd(3'd4, v);
        check("R6 cleared by read", v, 32'h0);

        // R7 trigger off: counter passes limit; R10 masked flag keeps irq low
        wr(3'd1, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd0, 32'h4);
        repeat (40) @(negedge clk);
        wr(3'd0, 32'h2);
        rd(3'd3, v);
        check("R7 no trigger counts on", v, 32'd20);
        check("R10 masked irq low", {31'd0, irq}, 32'd0);
        rd(3'd4, v);
        check("R6 flag without trigger", v, 32'h10);

        done = 1;
        report();
    end
endmodule